// File: doc/BRIEF.md
# Hardware Task Switch Sequencer

This block carries out a full hardware context switch when it is handed a 16-bit target selector. The selector points at a descriptor slot. That slot holds either a task-state descriptor or a one-level indirection gate that names one. The sequencer fetches the descriptor over a registered read port and applies its entry checks. If the checks pass, it writes the running register image to the outgoing task's state block. It then commits the switch by updating the task register, marking the incoming descriptor busy and raising the task-switched flag. Finally it reads the incoming image back into the register file.

Every fault raised before the commit is attributed to the outgoing task and leaves all architectural state untouched, so the triggering instruction can be retried. A fault raised after the commit is attributed to the incoming task. The caller starts a switch with a valid/ready handshake. It then waits for a one-cycle `done` or `fault` pulse. `fault` comes with a code and a context flag.

Top module: `tsw_seq`

## Requirements
- R1: After reset the unit is idle with `reqReady`=1, `busy`=0, `done`=0, `fault`=0, `trSel`=0x0008, `tsFlag`=0 and `cpl`=0.
- R2: A selector is laid out as index [15:3], table flag [2] and requested level [1:0]. A request whose table flag is 1 faults with code 1 one cycle after acceptance. A gate whose target has the table flag set faults with code 1.
- R3: The first descriptor fetched must satisfy dpl <= max(cpl, selector level), or the switch faults with code 3. The descriptor layout is: base [31:0], byte limit [47:32], dpl [49:48], present [50], busy [51], kind [53:52].
- R4: Kind 2 is a gate, and its target selector sits in bits [15:0]. The target descriptor is fetched without a privilege check. If the target is not kind 1, the switch faults with code 2. A first descriptor that is neither kind 1 nor kind 2 also faults with code 2.
- R5: The task-state descriptor must have present=1, or the switch faults with code 4. Its limit must be at least 4*WORDS-1, or the switch faults with code 5.
- R6: A fault with codes 1 to 5 reports `faultIncoming`=0. It performs no state-block, descriptor or register-file write, and it leaves `trSel`, `tsFlag` and `cpl` unchanged.
- R7: The save writes word k to old base + 4k, for k from 0 to WORDS-1. Word 0 is `reqNextIp` and word k is register k.
- R8: The commit rewrites the task-state descriptor with bit 51 set. It loads `trSel` with the task-state selector (the gate target when a gate is used) and sets `tsFlag`, which never clears.
- R9: The load writes register k with the word at new base + 4k. `cpl` becomes bits [1:0] of word CS_WORD (default 2), whatever the previous level was.
- R10: If word CS_WORD has a zero index field [15:3], the switch faults with code 6 and `faultIncoming`=1. Registers below CS_WORD are already loaded, `trSel`/`tsFlag` are already updated, and `cpl` is unchanged.
- R11: `reqReady` is high only while idle. A direct switch pulses `done` 2*WORDS+5 cycles after acceptance, and a gated switch takes 2 cycles more. A fault in the first check pulses 3 cycles after acceptance (5 through a gate). Code 6 pulses WORDS+CS_WORD+6 cycles after acceptance (+2 through a gate). `done` and `fault` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Switch request valid |
| reqReady | output | 1 | Unit idle and able to accept |
| reqSel | input | 16 | Target selector |
| reqNextIp | input | 32 | Address of the instruction after the trigger |
| busy | output | 1 | Switch in progress |
| done | output | 1 | One-cycle pulse on a completed switch |
| fault | output | 1 | One-cycle pulse on an aborted switch |
| faultCode | output | 3 | Fault cause, valid with `fault` |
| faultIncoming | output | 1 | 1 when the fault belongs to the incoming task |
| descRdEn | output | 1 | Descriptor read strobe |
| descWrEn | output | 1 | Descriptor write strobe |
| descIdx | output | 13 | Descriptor slot index |
| descWdata | output | 64 | Descriptor write data |
| descRdata | input | 64 | Descriptor read data, one cycle after `descRdEn` |
| ctxRdEn | output | 1 | State-block read strobe |
| ctxWrEn | output | 1 | State-block write strobe |
| ctxAddr | output | 32 | State-block byte address |
| ctxWdata | output | 32 | State-block write data |
| ctxRdata | input | 32 | State-block read data, one cycle after `ctxRdEn` |
| rfIdx | output | $clog2(WORDS) | Register file index |
| rfRdata | input | 32 | Register file combinational read data |
| rfWrEn | output | 1 | Register file write strobe |
| rfWdata | output | 32 | Register file write data |
| trSel | output | 16 | Task register selector |
| tsFlag | output | 1 | Task-switched status bit |
| cpl | output | 2 | Current privilege level |

## Verification
The bound assertions watch, on every cycle, several per-cycle relations. `done` and `fault` never occur together, and the unit is never both ready and busy. A pre-commit fault never coincides with a change of `trSel`, `tsFlag` or `cpl`. A descriptor write is always followed by `trSel` naming that slot, and the task-switched flag stays set once raised. Only the bench scenarios can show the rest: the exact ordering and content of the save and load traffic, the privilege comparison against each combination of levels, the one-level gate indirection and its failure modes, and the split of fault attribution around the commit point. The bench shows these by matching every write and every completion cycle against its own model.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  typedef enum logic [2:0] {
    F_NONE   = 3'd0,
    F_LOCAL  = 3'd1,
    F_TYPE   = 3'd2,
    F_PRIV   = 3'd3,
    F_ABSENT = 3'd4,
    F_LIMIT  = 3'd5,
    F_BADCS  = 3'd6
  } fault_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic latchReq;
    logic descRd;
    logic takeGate;
    logic latchTss;
    logic saveWr;
    logic commit;
    logic loadRd;
    logic rfWr;
    logic takeCpl;
  } strobe_t;

  localparam int BUSY_BIT = 51;
  localparam logic [1:0] K_TSS  = 2'b01;
  localparam logic [1:0] K_GATE = 2'b10;
endpackage

// File: rtl/tsw_ctrl.sv
module tsw_ctrl
  import tsw_pkg::*;
#(
  parameter int WORDS   = 8,
  parameter int CS_WORD = 2,
  parameter int CW      = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          reqTi,
  input  logic [1:0]    curRpl,
  input  logic [1:0]    cpl,
  input  logic [63:0]   descRdata,
  input  logic [31:0]   ctxRdata,
  output logic          reqReady,
  output logic          busy,
  output logic          done,
  output logic          fault,
  output logic          faultIncoming,
  output fault_e        faultCode,
  output strobe_t       stb,
  output logic [CW-1:0] cnt
);
  localparam logic [15:0] MIN_LIMIT = 16'(4 * WORDS - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CHECK, S_SAVE, S_COMMIT, S_LOAD, S_DONE, S_FAULT
  } state_e;

  state_e        st, stN;
  logic          hop, hopN, incN;
  logic [CW-1:0] cntN;
  fault_e        codeN;

  logic [1:0]  kind, dpl, maxPl;
  logic        present, csHit, csBad;
  logic [15:0] limit;
  logic        targetTi;
  logic        unusedBits;

  assign kind     = descRdata[53:52];
  assign dpl      = descRdata[49:48];
  assign present  = descRdata[50];
  assign limit    = descRdata[47:32];
  assign targetTi = descRdata[2];
  assign maxPl    = (cpl > curRpl) ? cpl : curRpl;
  assign csHit    = (cnt != '0) && ((cnt - 1'b1) == CW'(CS_WORD));
  assign csBad    = csHit && (ctxRdata[15:3] == '0);
  assign unusedBits = ^{descRdata[63:54], descRdata[51], descRdata[31:3],
                        descRdata[1:0], ctxRdata[31:16], ctxRdata[2:0]};

  assign reqReady = (st == S_IDLE);
  assign busy     = (st != S_IDLE);
  assign done     = (st == S_DONE);
  assign fault    = (st == S_FAULT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st            <= S_IDLE;
      hop           <= 1'b0;
      cnt           <= '0;
      faultCode     <= F_NONE;
      faultIncoming <= 1'b0;
    end else begin
      st            <= stN;
      hop           <= hopN;
      cnt           <= cntN;
      faultCode     <= codeN;
      faultIncoming <= incN;
    end
  end

  always_comb begin
    stN   = st;
    hopN  = hop;
    cntN  = cnt;
    codeN = faultCode;
    incN  = faultIncoming;
    stb   = '0;
    unique case (st)
      S_IDLE: if (reqValid) begin
        stb.latchReq = 1'b1;
        hopN  = 1'b0;
        incN  = 1'b0;
        codeN = F_NONE;
        if (reqTi) begin
          stN   = S_FAULT;
          codeN = F_LOCAL;
        end else stN = S_FETCH;
      end
      S_FETCH: begin
        stb.descRd = 1'b1;
        stN = S_CHECK;
      end
      S_CHECK: begin
        if (!hop && (dpl > maxPl)) begin
          stN = S_FAULT; codeN = F_PRIV;
        end else if (!hop && kind == K_GATE) begin
          if (targetTi) begin
            stN = S_FAULT; codeN = F_LOCAL;
          end else begin
            stb.takeGate = 1'b1;
            hopN = 1'b1;
            stN  = S_FETCH;
          end
        end else if (kind != K_TSS) begin
          stN = S_FAULT; codeN = F_TYPE;
        end else if (!present) begin
          stN = S_FAULT; codeN = F_ABSENT;
        end else if (limit < MIN_LIMIT) begin
          stN = S_FAULT; codeN = F_LIMIT;
        end else begin
          stb.latchTss = 1'b1;
          cntN = '0;
          stN  = S_SAVE;
        end
      end
      S_SAVE: begin
        stb.saveWr = 1'b1;
        if (cnt == CW'(WORDS - 1)) stN = S_COMMIT;
        else cntN = cnt + 1'b1;
      end
      S_COMMIT: begin
        stb.commit = 1'b1;
        cntN = '0;
        stN  = S_LOAD;
      end
      S_LOAD: begin
        stb.loadRd = (cnt != CW'(WORDS));
        if (csBad) begin
          stN = S_FAULT; codeN = F_BADCS; incN = 1'b1;
        end else begin
          stb.rfWr    = (cnt != '0);
          stb.takeCpl = csHit;
          if (cnt == CW'(WORDS)) stN = S_DONE;
          else cntN = cnt + 1'b1;
        end
      end
      S_DONE:  stN = S_IDLE;
      S_FAULT: stN = S_IDLE;
      default: stN = S_IDLE;
    endcase
  end
endmodule

// File: rtl/tsw_dp.sv
module tsw_dp
  import tsw_pkg::*;
#(
  parameter int          WORDS         = 8,
  parameter int          IDXW          = 3,
  parameter int          CW            = 4,
  parameter logic [15:0] RESET_TR_SEL  = 16'h0008,
  parameter logic [31:0] RESET_TR_BASE = 32'h0000_1000
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         stb,
  input  logic [CW-1:0]   cnt,
  input  logic [15:0]     reqSel,
  input  logic [31:0]     reqNextIp,
  input  logic [63:0]     descRdata,
  input  logic [31:0]     ctxRdata,
  input  logic [31:0]     rfRdata,
  output logic [1:0]      curRpl,
  output logic            descRdEn,
  output logic            descWrEn,
  output logic [12:0]     descIdx,
  output logic [63:0]     descWdata,
  output logic            ctxRdEn,
  output logic            ctxWrEn,
  output logic [31:0]     ctxAddr,
  output logic [31:0]     ctxWdata,
  output logic [IDXW-1:0] rfIdx,
  output logic            rfWrEn,
  output logic [31:0]     rfWdata,
  output logic [15:0]     trSel,
  output logic            tsFlag,
  output logic [1:0]      cpl
);
  logic [15:0] selQ;
  logic [31:0] nextIpQ, trBaseQ;
  logic [63:0] tssDescQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ     <= '0;
      nextIpQ  <= '0;
      tssDescQ <= '0;
      trSel    <= RESET_TR_SEL;
      trBaseQ  <= RESET_TR_BASE;
      tsFlag   <= 1'b0;
      cpl      <= 2'd0;
    end else begin
      if (stb.latchReq) begin
        selQ    <= reqSel;
        nextIpQ <= reqNextIp;
      end
      if (stb.takeGate) selQ     <= descRdata[15:0];
      if (stb.latchTss) tssDescQ <= descRdata;
      if (stb.commit) begin
        trSel   <= selQ;
        trBaseQ <= tssDescQ[31:0];
        tsFlag  <= 1'b1;
      end
      if (stb.takeCpl) cpl <= ctxRdata[1:0];
    end
  end

  assign curRpl    = selQ[1:0];
  assign descRdEn  = stb.descRd;
  assign descWrEn  = stb.commit;
  assign descIdx   = selQ[15:3];
  assign descWdata = tssDescQ | (64'd1 << BUSY_BIT);

  // one address generator serves both save and load, base switches at commit
  assign ctxRdEn  = stb.loadRd;
  assign ctxWrEn  = stb.saveWr;
  assign ctxAddr  = trBaseQ + (32'(cnt) << 2);
  assign ctxWdata = (cnt == '0) ? nextIpQ : rfRdata;

  assign rfIdx   = stb.rfWr ? IDXW'(cnt - 1'b1) : IDXW'(cnt);
  assign rfWrEn  = stb.rfWr;
  assign rfWdata = ctxRdata;
endmodule

// File: rtl/tsw_seq.sv
module tsw_seq
  import tsw_pkg::*;
#(
  parameter int          WORDS         = 8,
  parameter int          CS_WORD       = 2,
  parameter logic [15:0] RESET_TR_SEL  = 16'h0008,
  parameter logic [31:0] RESET_TR_BASE = 32'h0000_1000
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  output logic                       reqReady,
  input  logic [15:0]                reqSel,
  input  logic [31:0]                reqNextIp,
  output logic                       busy,
  output logic                       done,
  output logic                       fault,
  output logic [2:0]                 faultCode,
  output logic                       faultIncoming,
  output logic                       descRdEn,
  output logic                       descWrEn,
  output logic [12:0]                descIdx,
  output logic [63:0]                descWdata,
  input  logic [63:0]                descRdata,
  output logic                       ctxRdEn,
  output logic                       ctxWrEn,
  output logic [31:0]                ctxAddr,
  output logic [31:0]                ctxWdata,
  input  logic [31:0]                ctxRdata,
  output logic [$clog2(WORDS)-1:0]   rfIdx,
  input  logic [31:0]                rfRdata,
  output logic                       rfWrEn,
  output logic [31:0]                rfWdata,
  output logic [15:0]                trSel,
  output logic                       tsFlag,
  output logic [1:0]                 cpl
);
  localparam int IDXW = $clog2(WORDS);
  localparam int CW   = $clog2(WORDS + 1);

  strobe_t       stb;
  logic [CW-1:0] cnt;
  logic [1:0]    curRpl;
  fault_e        code;

  assign faultCode = code;

  tsw_ctrl #(.WORDS(WORDS), .CS_WORD(CS_WORD), .CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqTi(reqSel[2]),
    .curRpl(curRpl), .cpl(cpl), .descRdata(descRdata), .ctxRdata(ctxRdata),
    .reqReady(reqReady), .busy(busy), .done(done), .fault(fault),
    .faultIncoming(faultIncoming), .faultCode(code), .stb(stb), .cnt(cnt)
  );

  tsw_dp #(.WORDS(WORDS), .IDXW(IDXW), .CW(CW),
           .RESET_TR_SEL(RESET_TR_SEL), .RESET_TR_BASE(RESET_TR_BASE)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cnt(cnt), .reqSel(reqSel),
    .reqNextIp(reqNextIp), .descRdata(descRdata), .ctxRdata(ctxRdata),
    .rfRdata(rfRdata), .curRpl(curRpl), .descRdEn(descRdEn),
    .descWrEn(descWrEn), .descIdx(descIdx), .descWdata(descWdata),
    .ctxRdEn(ctxRdEn), .ctxWrEn(ctxWrEn), .ctxAddr(ctxAddr),
    .ctxWdata(ctxWdata), .rfIdx(rfIdx), .rfWrEn(rfWrEn), .rfWdata(rfWdata),
    .trSel(trSel), .tsFlag(tsFlag), .cpl(cpl)
  );
endmodule

// File: rtl/tsw_seq_chk.sv
module tsw_seq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqReady,
  input logic        busy,
  input logic        done,
  input logic        fault,
  input logic        faultIncoming,
  input logic        descWrEn,
  input logic [12:0] descIdx,
  input logic        ctxWrEn,
  input logic        rfWrEn,
  input logic [15:0] trSel,
  input logic        tsFlag,
  input logic [1:0]  cpl
);
  p_ready_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !busy);

  p_done_fault_excl_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(done && fault));

  p_outgoing_clean_r6: assert property (@(posedge clk) disable iff (!rstN)
    (fault && !faultIncoming) |-> ($stable(trSel) && $stable(tsFlag) && $stable(cpl)));

  p_commit_tr_r8: assert property (@(posedge clk) disable iff (!rstN)
    descWrEn |=> (trSel[15:3] == $past(descIdx)) && tsFlag);

  p_ts_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    tsFlag |=> tsFlag);

  p_done_ts_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> tsFlag);

  p_rf_wr_phase_r9: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> (busy && !ctxWrEn && !descWrEn));

  p_incoming_committed_r10: assert property (@(posedge clk) disable iff (!rstN)
    (fault && faultIncoming) |-> tsFlag);
endmodule

bind tsw_seq tsw_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .busy(busy), .done(done),
  .fault(fault), .faultIncoming(faultIncoming), .descWrEn(descWrEn),
  .descIdx(descIdx), .ctxWrEn(ctxWrEn), .rfWrEn(rfWrEn), .trSel(trSel),
  .tsFlag(tsFlag), .cpl(cpl)
);

// File: tb/sim_tsw_seq.sv
module sim_tsw_seq;
  localparam int W  = 8;
  localparam int CS = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [15:0] reqSel = '0;
  logic [31:0] reqNextIp = '0;
  logic        busy, done, fault, faultIncoming;
  logic [2:0]  faultCode;
  logic        descRdEn, descWrEn;
  logic [12:0] descIdx;
  logic [63:0] descWdata;
  logic [63:0] descRdata = '0;
  logic        ctxRdEn, ctxWrEn;
  logic [31:0] ctxAddr, ctxWdata;
  logic [31:0] ctxRdata = '0;
  logic [2:0]  rfIdx;
  logic [31:0] rfRdata;
  logic        rfWrEn;
  logic [31:0] rfWdata;
  logic [15:0] trSel;
  logic        tsFlag;
  logic [1:0]  cpl;

  always #10 clk = ~clk;

  tsw_seq u0 (.*);

  // environment memories
  logic [63:0] descMem [0:31];
  logic [31:0] ctxMem [logic [31:0]];
  logic [31:0] rf [0:W-1];

  function automatic logic [31:0] rdCtx(input logic [31:0] a);
    return ctxMem.exists(a) ? ctxMem[a] : 32'h0;
  endfunction

  assign rfRdata = rf[rfIdx];

  always @(posedge clk) begin
    if (descRdEn) descRdata <= descMem[descIdx[4:0]];
    if (descWrEn) descMem[descIdx[4:0]] <= descWdata;
    if (ctxRdEn)  ctxRdata <= rdCtx(ctxAddr);
    if (ctxWrEn)  ctxMem[ctxAddr] = ctxWdata;
    if (rfWrEn)   rf[rfIdx] <= rfWdata;
  end

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(input string r, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  // reference model state
  int          mCpl;
  logic [15:0] mTr;
  logic [31:0] mTrBase;
  logic        mTs;
  logic [31:0] qCtxA[$], qCtxD[$], qRfD[$];
  int          qRfI[$];
  bit          expDescWr, commitExp;
  logic [12:0] expDescIdx;
  logic [63:0] expDescD;
  int          expCode, expInc, expCyc, nCpl;
  logic [15:0] nTr;
  logic [31:0] nBase;

  function automatic logic [63:0] mk(input logic [31:0] base, input logic [15:0] lim,
                                     input logic [1:0] dpl, input logic p, input logic [1:0] kind);
    return {10'b0, kind, 1'b0, p, dpl, lim, base};
  endfunction

  task automatic predict(input logic [15:0] s, input logic [31:0] ip);
    logic [63:0] d;
    logic [15:0] t;
    logic [31:0] w;
    int extra, maxPl;
    qCtxA.delete(); qCtxD.delete(); qRfI.delete(); qRfD.delete();
    expDescWr = 0; commitExp = 0; expCode = 0; expInc = 0; extra = 0;
    t = s; nCpl = mCpl;
    maxPl = (mCpl > int'(s[1:0])) ? mCpl : int'(s[1:0]);
    if (s[2]) begin expCode = 1; expCyc = 1; return; end
    d = descMem[s[7:3]];
    if (int'(d[49:48]) > maxPl) begin expCode = 3; expCyc = 3; return; end
    if (d[53:52] == 2'b10) begin
      t = d[15:0]; extra = 2;
      if (t[2]) begin expCode = 1; expCyc = 3; return; end
      d = descMem[t[7:3]];
    end
    if (d[53:52] != 2'b01) begin expCode = 2; expCyc = 3 + extra; return; end
    if (!d[50]) begin expCode = 4; expCyc = 3 + extra; return; end
    if (d[47:32] < 16'(4 * W - 1)) begin expCode = 5; expCyc = 3 + extra; return; end
    for (int k = 0; k < W; k++) begin
      qCtxA.push_back(mTrBase + 32'(4 * k));
      qCtxD.push_back(k == 0 ? ip : rf[k]);
    end
    expDescWr = 1; expDescIdx = t[15:3]; expDescD = d | (64'd1 << 51);
    commitExp = 1; nTr = t; nBase = d[31:0];
    for (int k = 0; k < W; k++) begin
      w = rdCtx(d[31:0] + 32'(4 * k));
      if (k == CS && w[15:3] == 13'd0) begin
        expCode = 6; expInc = 1; expCyc = 6 + W + k + extra; return;
      end
      qRfI.push_back(k); qRfD.push_back(w);
      if (k == CS) nCpl = int'(w[1:0]);
    end
    expCyc = 5 + 2 * W + extra;
  endtask

  task automatic sw(input logic [15:0] s, input logic [31:0] ip, input string tag);
    int k;
    bit fin, descSeen;
    predict(s, ip);
    @(negedge clk);
    reqValid = 1'b1; reqSel = s; reqNextIp = ip;
    k = 0; fin = 0; descSeen = 0;
    while (!fin && k < 200) begin
      @(negedge clk);
      reqValid = 1'b0;
      k++;
      if (ctxWrEn) begin
        if (qCtxA.size() == 0) chk("R6", "unexpected state write", 1, 0);
        else begin
          chk("R7", "save address", ctxAddr, qCtxA.pop_front());
          chk("R7", "save data", ctxWdata, qCtxD.pop_front());
        end
      end
      if (rfWrEn) begin
        if (qRfI.size() == 0) chk("R6", "unexpected register write", 1, 0);
        else begin
          chk("R9", "load index", rfIdx, qRfI.pop_front());
          chk("R9", "load data", rfWdata, qRfD.pop_front());
        end
      end
      if (descWrEn) begin
        descSeen = 1;
        chk("R8", "descriptor write expected", 1, expDescWr);
        chk("R8", "descriptor index", descIdx, expDescIdx);
        chk("R8", "descriptor data", descWdata, expDescD);
      end
      if (done || fault) begin
        fin = 1;
        chk(tag, "done pulse", done, expCode == 0);
        chk(tag, "fault code", fault ? faultCode : 3'd0, expCode);
        if (fault) chk(expInc ? "R10" : "R6", "fault context", faultIncoming, expInc);
        chk("R11", "completion cycle", k, expCyc);
      end
    end
    chk("R11", "switch completed", fin, 1);
    chk("R7", "save words left", qCtxA.size(), 0);
    chk("R9", "load words left", qRfI.size(), 0);
    chk("R8", "descriptor write seen", descSeen, expDescWr);
    if (commitExp) begin mTr = nTr; mTrBase = nBase; mTs = 1; end
    if (expCode == 0) mCpl = nCpl;
    @(negedge clk);
    chk(tag, "task register", trSel, mTr);
    chk(tag, "task switched flag", tsFlag, mTs);
    chk(tag, "privilege level", cpl, mCpl);
    chk("R11", "ready after switch", reqReady, 1);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) descMem[i] = '0;
    for (int i = 0; i < W; i++) rf[i] = 32'h1000_0000 + i;
    descMem[2]  = mk(32'h2000, 16'd31, 2'd0, 1, 2'b01);
    descMem[3]  = mk(32'h3000, 16'd40, 2'd0, 1, 2'b01);
    descMem[4]  = mk(32'h0018, 16'd0,  2'd3, 1, 2'b10);
    descMem[5]  = mk(32'h5000, 16'd31, 2'd1, 1, 2'b01);
    descMem[6]  = mk(32'h6000, 16'd31, 2'd0, 0, 2'b01);
    descMem[7]  = mk(32'h7000, 16'd30, 2'd0, 1, 2'b01);
    descMem[8]  = mk(32'h8000, 16'd31, 2'd0, 1, 2'b00);
    descMem[9]  = mk(32'h0020, 16'd0,  2'd0, 1, 2'b10);
    descMem[10] = mk(32'h0034, 16'd0,  2'd0, 1, 2'b10);
    descMem[11] = mk(32'hB000, 16'd31, 2'd0, 1, 2'b01);
    for (int k = 0; k < W; k++) begin
      ctxMem[32'h2000 + 4 * k] = 32'hA000_0000 + k;
      ctxMem[32'h3000 + 4 * k] = 32'hB000_0000 + k;
      ctxMem[32'h5000 + 4 * k] = 32'hC000_0000 + k;
      ctxMem[32'hB000 + 4 * k] = 32'hF000_0000 + k;
    end
    ctxMem[32'h2000 + 4 * CS] = 32'h0000_001B;
    ctxMem[32'h3000 + 4 * CS] = 32'h0000_0010;
    ctxMem[32'h5000 + 4 * CS] = 32'h0000_0021;
    ctxMem[32'hB000 + 4 * CS] = 32'h0000_0000;
    mCpl = 0; mTr = 16'h0008; mTrBase = 32'h1000; mTs = 0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "reset ready", reqReady, 1);
    chk("R1", "reset busy", busy, 0);
    chk("R1", "reset done/fault", {done, fault}, 0);
    chk("R1", "reset task register", trSel, 16'h0008);
    chk("R1", "reset flag", tsFlag, 0);
    chk("R1", "reset level", cpl, 0);

    sw(16'h0010, 32'h0000_4004, "R7");  // direct, level becomes 3
    sw(16'h0023, 32'h0000_5008, "R4");  // through gate to slot 3, level back to 0
    sw(16'h0028, 32'h0000_600C, "R3");  // dpl 1 > max(0,0)
    sw(16'h0029, 32'h0000_7010, "R3");  // requested level 1 lifts the limit
    sw(16'h0030, 32'h0000_8014, "R5");  // absent
    sw(16'h0038, 32'h0000_9018, "R5");  // limit one short
    sw(16'h0014, 32'h0000_A01C, "R2");  // local table flag
    sw(16'h0040, 32'h0000_B020, "R4");  // kind 0
    sw(16'h0048, 32'h0000_C024, "R4");  // gate to gate
    sw(16'h0050, 32'h0000_D028, "R2");  // gate target with table flag
    sw(16'h0058, 32'h0000_E02C, "R10"); // null code selector in new image
    sw(16'h0018, 32'h0000_F030, "R9");  // direct back to slot 3
    sw(16'h0020, 32'h0001_0034, "R3");  // gate dpl 3 from level 0

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R11 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule